// File: doc/BRIEF.md
# Byte Register Machine Decode and Execute Core

This block decodes and executes the 16-bit instruction words of a small interpreted byte machine. It keeps sixteen 8-bit general registers (register 15 doubles as the arithmetic flag), a 12-bit index, a 12-bit program counter, a stack pointer, and two 8-bit timer registers. One fetched word is accepted per step over a valid/ready input. Most words complete in the accepting cycle. Calls and returns use a memory stack that grows downward and is reached through a request port.

Drawing, screen clear, key tests, decimal conversion, glyph lookup and block transfer words are not executed here. The core raises a one-cycle dispatch strobe that carries the word to external units. Timer countdown and random generation happen outside the block; a random byte arrives on an input pin. Undefined words raise a one-cycle trap and change no state.

Back-pressure: `ins_ready` is high only while no stack access is pending, and a word transfers when `ins_valid` and `ins_ready` are both high. A stack request holds `stk_valid`, `stk_we`, `stk_addr` and `stk_wdata` steady until `stk_ready` is high. Read data on `stk_rdata` is taken in that same cycle.

Top module: `bvm_core`

## Requirements
- R1: After reset the PC is RESET_PC (default 0x200), the stack pointer is STACK_TOP (default 0xEA0), and the index, timers and all sixteen registers are zero. `ins_ready` is 1, and `stk_valid`, `ext_stb` and `trap` are 0.
- R2: A word is consumed only on a cycle where `ins_valid` and `ins_ready` are both 1. With `ins_valid` low the state is held. `ins_ready` is 0 while a stack request is outstanding.
- R3: The top nibble selects the class. 1nnn loads the PC with nnn, and Annn loads the index with nnn.
- R4: 3xkk skips when Vx equals kk, and 4xkk skips when they differ. 5xy0 skips when Vx equals Vy, and 9xy0 skips when they differ. A skip adds 4 to the PC; otherwise the PC adds 2.
- R5: 6xkk writes kk to Vx. 7xkk adds kk to Vx modulo 256 and leaves register 15 unchanged.
- R6: 8xyN with N = 0, 1, 2, 3, 4, 5 writes Vx with, in that order, Vy, Vx|Vy, Vx&Vy, Vx^Vy, Vx+Vy mod 256, and Vx-Vy mod 256.
- R7: 8xy4 sets register 15 to 1 when the 9-bit sum is above 255, else 0. 8xy5 sets it to 1 when Vx >= Vy, else 0. When x is 15, the flag value is what register 15 holds afterwards.
- R8: 2nnn first lowers the stack pointer by 2. It then requests a write (`stk_we`=1) of the zero-extended return address, the call's PC plus 2, at the new stack pointer. When `stk_ready` is seen, the PC becomes nnn.
- R9: 00EE requests a read at the stack pointer. On `stk_ready` the PC takes `stk_rdata[11:0]`, ignoring the upper bits, and the stack pointer rises by 2.
- R10: Cxkk writes `rnd_byte & kk` to Vx.
- R11: Fx07 copies the delay timer to Vx. Fx15 and Fx18 load the delay and sound timers from Vx. Fx1E adds Vx to the index modulo 4096.
- R12: 00E0, Dxyn, Ex9E, ExA1, Fx29, Fx33, Fx55 and Fx65 pulse `ext_stb` for one cycle with the word on `ext_word` and advance the PC by 2. No register changes.
- R13: Any other word, including class 5, 8 or 9 words with an undefined low nibble, pulses `trap` for one cycle. The PC and registers stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Core can take a word |
| ins_word | input | 16 | Instruction word |
| rnd_byte | input | 8 | Random byte for class C |
| stk_valid | output | 1 | Stack request pending |
| stk_ready | input | 1 | Stack memory completes the request |
| stk_we | output | 1 | 1 = write, 0 = read |
| stk_addr | output | AW | Stack byte address |
| stk_wdata | output | 16 | Return address to store |
| stk_rdata | input | 16 | Return address read back |
| ext_stb | output | 1 | One-cycle dispatch strobe |
| ext_word | output | 16 | Word handed to external units |
| trap | output | 1 | One-cycle illegal-word pulse |
| pc | output | AW | Program counter |
| sp | output | AW | Stack pointer |
| idx | output | AW | Index register |
| dly | output | 8 | Delay timer register |
| snd | output | 8 | Sound timer register |
| rd_sel | input | 4 | Register read select |
| rd_data | output | 8 | Value of the selected register |

## Verification
The hardest case to reach is an arithmetic word whose destination is register 15. The result and the flag then compete for one register, and the flag must win. To get there, the stimulus first loads register 15 with values whose sum or difference differs from the flag: 0xF0 plus 0xFF, and 0x01 minus 0xFF. A second hard case is a stalled stack request. The bench withholds `stk_ready` for several cycles and checks that the request stays steady and that no new word is taken. It also returns read data with the upper nibble set, to show that only the low 12 bits reach the PC.

// File: rtl/bvm_pkg.sv
package bvm_pkg;
  typedef enum logic [4:0] {
    OP_ILL, OP_JMP, OP_CALL, OP_RET, OP_SEQI, OP_SNEI, OP_SEQR, OP_SNER,
    OP_LDI, OP_ADDI, OP_ALU, OP_LDIX, OP_RND, OP_GDLY, OP_SDLY, OP_SSND,
    OP_ADIX, OP_EXT
  } op_e;

  typedef struct packed {
    op_e         op;
    logic [3:0]  x;
    logic [3:0]  y;
    logic [7:0]  imm;
    logic [11:0] nnn;
    logic [2:0]  fn;
  } dec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_POP} st_e;
endpackage

// File: rtl/bvm_decode.sv
module bvm_decode
  import bvm_pkg::*;
(
  input  logic [15:0] word,
  output dec_t        dec
);
  logic [3:0] lo;
  assign lo = word[3:0];

  always_comb begin
    dec.x   = word[11:8];
    dec.y   = word[7:4];
    dec.imm = word[7:0];
    dec.nnn = word[11:0];
    dec.fn  = word[2:0];
    dec.op  = OP_ILL;
    unique case (word[15:12])
      4'h0: if (word == 16'h00EE) dec.op = OP_RET;
            else if (word == 16'h00E0) dec.op = OP_EXT;
      4'h1: dec.op = OP_JMP;
      4'h2: dec.op = OP_CALL;
      4'h3: dec.op = OP_SEQI;
      4'h4: dec.op = OP_SNEI;
      4'h5: if (lo == 4'h0) dec.op = OP_SEQR;
      4'h6: dec.op = OP_LDI;
      4'h7: dec.op = OP_ADDI;
      4'h8: if (lo <= 4'h5) dec.op = OP_ALU;
      4'h9: if (lo == 4'h0) dec.op = OP_SNER;
      4'hA: dec.op = OP_LDIX;
      4'hC: dec.op = OP_RND;
      4'hD: dec.op = OP_EXT;
      4'hE: if (word[7:0] == 8'h9E || word[7:0] == 8'hA1) dec.op = OP_EXT;
      4'hF: begin
        case (word[7:0])
          8'h07: dec.op = OP_GDLY;
          8'h15: dec.op = OP_SDLY;
          8'h18: dec.op = OP_SSND;
          8'h1E: dec.op = OP_ADIX;
          8'h29, 8'h33, 8'h55, 8'h65: dec.op = OP_EXT;
          default: dec.op = OP_ILL;
        endcase
      end
      default: dec.op = OP_ILL;
    endcase
  end
endmodule

// File: rtl/bvm_alu.sv
module bvm_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [2:0]    fn,
  output logic [DW-1:0] res,
  output logic          flag,
  output logic          flag_we
);
  logic [DW:0] sum;
  assign sum = {1'b0, a} + {1'b0, b};

  always_comb begin
    res     = b;
    flag    = 1'b0;
    flag_we = 1'b0;
    case (fn)
      3'd0: res = b;
      3'd1: res = a | b;
      3'd2: res = a & b;
      3'd3: res = a ^ b;
      3'd4: begin res = sum[DW-1:0]; flag = sum[DW]; flag_we = 1'b1; end
      3'd5: begin res = a - b; flag = (a >= b); flag_we = 1'b1; end
      default: res = b;
    endcase
  end
endmodule

// File: rtl/bvm_regfile.sv
module bvm_regfile #(
  parameter int DW   = 8,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [DW-1:0]           wd,
  input  logic                    fwe,
  input  logic [DW-1:0]           fd,
  input  logic [$clog2(NREG)-1:0] ra_x,
  input  logic [$clog2(NREG)-1:0] ra_y,
  input  logic [$clog2(NREG)-1:0] ra_d,
  output logic [DW-1:0]           rx,
  output logic [DW-1:0]           ry,
  output logic [DW-1:0]           rd,
  output logic [DW-1:0]           vf
);
  localparam int FLAG = NREG - 1;
  logic [DW-1:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs[i] <= '0;
      else if (fwe && i == FLAG) regs[i] <= fd;
      else if (we && wa == i) regs[i] <= wd;
    end
  end

  assign rx = regs[ra_x];
  assign ry = regs[ra_y];
  assign rd = regs[ra_d];
  assign vf = regs[FLAG];

  p_flag_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwe && we && wa == FLAG) |=> (vf == $past(fd)));
endmodule

// File: rtl/bvm_core.sv
module bvm_core
  import bvm_pkg::*;
#(
  parameter int          AW        = 12,
  parameter int          DW        = 8,
  parameter int          NREG      = 16,
  parameter int          IW        = 16,
  parameter logic [11:0] RESET_PC  = 12'h200,
  parameter logic [11:0] STACK_TOP = 12'hEA0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ins_valid,
  output logic                    ins_ready,
  input  logic [IW-1:0]           ins_word,
  input  logic [DW-1:0]           rnd_byte,
  output logic                    stk_valid,
  input  logic                    stk_ready,
  output logic                    stk_we,
  output logic [AW-1:0]           stk_addr,
  output logic [IW-1:0]           stk_wdata,
  input  logic [IW-1:0]           stk_rdata,
  output logic                    ext_stb,
  output logic [IW-1:0]           ext_word,
  output logic                    trap,
  output logic [AW-1:0]           pc,
  output logic [AW-1:0]           sp,
  output logic [AW-1:0]           idx,
  output logic [DW-1:0]           dly,
  output logic [DW-1:0]           snd,
  input  logic [$clog2(NREG)-1:0] rd_sel,
  output logic [DW-1:0]           rd_data
);
  localparam int RW = $clog2(NREG);
  localparam logic [AW-1:0] STEP = AW'(2);

  dec_t dec;
  st_e  st_q;
  logic [AW-1:0] pc_q, sp_q, idx_q, ret_q, tgt_q;
  logic [DW-1:0] dly_q, snd_q, vx, vy, vf, alu_res;
  logic          alu_flag, alu_fwe, acc;
  logic          we, fwe, skip;
  logic [DW-1:0] wd, fd;

  bvm_decode u_dec (.word(ins_word), .dec(dec));

  bvm_alu #(.DW(DW)) u_alu (
    .a(vx), .b(vy), .fn(dec.fn), .res(alu_res), .flag(alu_flag), .flag_we(alu_fwe)
  );

  bvm_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(we), .wa(dec.x[RW-1:0]), .wd(wd),
    .fwe(fwe), .fd(fd), .ra_x(dec.x[RW-1:0]), .ra_y(dec.y[RW-1:0]),
    .ra_d(rd_sel), .rx(vx), .ry(vy), .rd(rd_data), .vf(vf)
  );

  assign ins_ready = (st_q == ST_IDLE);
  assign acc       = ins_valid && ins_ready;

  always_comb begin
    we   = 1'b0;
    wd   = '0;
    fwe  = 1'b0;
    fd   = '0;
    skip = 1'b0;
    case (dec.op)
      OP_SEQI: skip = (vx == dec.imm);
      OP_SNEI: skip = (vx != dec.imm);
      OP_SEQR: skip = (vx == vy);
      OP_SNER: skip = (vx != vy);
      OP_LDI:  begin we = acc; wd = dec.imm; end
      OP_ADDI: begin we = acc; wd = vx + dec.imm; end
      OP_ALU:  begin
        we  = acc;
        wd  = alu_res;
        fwe = acc && alu_fwe;
        fd  = {{(DW-1){1'b0}}, alu_flag};
      end
      OP_RND:  begin we = acc; wd = rnd_byte & dec.imm; end
      OP_GDLY: begin we = acc; wd = dly_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pc_q     <= AW'(RESET_PC);
      sp_q     <= AW'(STACK_TOP);
      idx_q    <= '0;
      dly_q    <= '0;
      snd_q    <= '0;
      ret_q    <= '0;
      tgt_q    <= '0;
      ext_stb  <= 1'b0;
      ext_word <= '0;
      trap     <= 1'b0;
    end else begin
      ext_stb <= 1'b0;
      trap    <= 1'b0;
      case (st_q)
        ST_IDLE: if (acc) begin
          pc_q <= pc_q + STEP;
          case (dec.op)
            OP_JMP:  pc_q <= AW'(dec.nnn);
            OP_CALL: begin
              pc_q  <= pc_q;
              sp_q  <= sp_q - STEP;
              ret_q <= pc_q + STEP;
              tgt_q <= AW'(dec.nnn);
              st_q  <= ST_PUSH;
            end
            OP_RET:  begin pc_q <= pc_q; st_q <= ST_POP; end
            OP_SEQI, OP_SNEI, OP_SEQR, OP_SNER:
              if (skip) pc_q <= pc_q + STEP + STEP;
            OP_LDIX: idx_q <= AW'(dec.nnn);
            OP_ADIX: idx_q <= idx_q + AW'(vx);
            OP_SDLY: dly_q <= vx;
            OP_SSND: snd_q <= vx;
            OP_EXT:  begin ext_stb <= 1'b1; ext_word <= ins_word; end
            OP_ILL:  begin pc_q <= pc_q; trap <= 1'b1; end
            default: ;
          endcase
        end
        ST_PUSH: if (stk_ready) begin
          pc_q <= tgt_q;
          st_q <= ST_IDLE;
        end
        ST_POP: if (stk_ready) begin
          pc_q <= AW'(stk_rdata[11:0]);
          sp_q <= sp_q + STEP;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign stk_valid = (st_q != ST_IDLE);
  assign stk_we    = (st_q == ST_PUSH);
  assign stk_addr  = sp_q;
  assign stk_wdata = IW'(ret_q);
  assign pc  = pc_q;
  assign sp  = sp_q;
  assign idx = idx_q;
  assign dly = dly_q;
  assign snd = snd_q;

  p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_ready && stk_valid));
  p_stk_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_addr)
      && $stable(stk_we) && $stable(stk_wdata)));
  p_call_sp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dec.op == OP_CALL) |=> (sp == $past(sp) - STEP && stk_we));
  p_ret_sp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && !stk_we && stk_ready) |=> (sp == $past(sp) + STEP));
  p_trap_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dec.op == OP_ILL) |=> (trap && pc == $past(pc)));
  p_addi_vf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dec.op == OP_ADDI && dec.x != 4'hF) |=> $stable(vf));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ready && !ins_valid) |=> $stable(pc));
endmodule

// File: tb/sim_bvm_core.sv
`timescale 1ns/1ps
module sim_bvm_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0;
  logic ins_ready;
  logic [15:0] ins_word = '0;
  logic [7:0] rnd_byte = '0;
  logic stk_valid, stk_we;
  logic stk_ready = 1'b0;
  logic [11:0] stk_addr;
  logic [15:0] stk_wdata;
  logic [15:0] stk_rdata = '0;
  logic ext_stb, trap;
  logic [15:0] ext_word;
  logic [11:0] pc, sp, idx;
  logic [7:0] dly, snd, rd_data;
  logic [3:0] rd_sel = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [15:0] saved_wr;

  always #2.5 clk = ~clk;

  bvm_core u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .rnd_byte(rnd_byte), .stk_valid(stk_valid),
    .stk_ready(stk_ready), .stk_we(stk_we), .stk_addr(stk_addr),
    .stk_wdata(stk_wdata), .stk_rdata(stk_rdata), .ext_stb(ext_stb),
    .ext_word(ext_word), .trap(trap), .pc(pc), .sp(sp), .idx(idx),
    .dly(dly), .snd(snd), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // word, rnd, reg, expected reg, expected flag reg, expected pc
  localparam int NV = 31;
  localparam logic [55:0] VEC [NV] = '{
    {16'h6A05, 8'h00, 4'hA, 8'h05, 8'h00, 12'h202},  // R5
    {16'h6BFF, 8'h00, 4'hB, 8'hFF, 8'h00, 12'h204},  // R5
    {16'h8AB4, 8'h00, 4'hA, 8'h04, 8'h01, 12'h206},  // R6 R7 carry
    {16'h7AFE, 8'h00, 4'hA, 8'h02, 8'h01, 12'h208},  // R5 flag kept
    {16'h8AB5, 8'h00, 4'hA, 8'h03, 8'h00, 12'h20A},  // R7 borrow
    {16'h6C03, 8'h00, 4'hC, 8'h03, 8'h00, 12'h20C},
    {16'h8AC5, 8'h00, 4'hA, 8'h00, 8'h01, 12'h20E},  // R7 equal
    {16'h6A3C, 8'h00, 4'hA, 8'h3C, 8'h01, 12'h210},
    {16'h8AB1, 8'h00, 4'hA, 8'hFF, 8'h01, 12'h212},  // R6 or
    {16'h8AC2, 8'h00, 4'hA, 8'h03, 8'h01, 12'h214},  // R6 and
    {16'h8AB3, 8'h00, 4'hA, 8'hFC, 8'h01, 12'h216},  // R6 xor
    {16'h8AC0, 8'h00, 4'hA, 8'h03, 8'h01, 12'h218},  // R6 move
    {16'h3A03, 8'h00, 4'hA, 8'h03, 8'h01, 12'h21C},  // R4
    {16'h3A04, 8'h00, 4'hA, 8'h03, 8'h01, 12'h21E},
    {16'h4A04, 8'h00, 4'hA, 8'h03, 8'h01, 12'h222},
    {16'h4A03, 8'h00, 4'hA, 8'h03, 8'h01, 12'h224},
    {16'h5AC0, 8'h00, 4'hA, 8'h03, 8'h01, 12'h228},
    {16'h9AC0, 8'h00, 4'hA, 8'h03, 8'h01, 12'h22A},
    {16'h9AB0, 8'h00, 4'hA, 8'h03, 8'h01, 12'h22E},
    {16'h5AB0, 8'h00, 4'hA, 8'h03, 8'h01, 12'h230},
    {16'hCD0F, 8'hA5, 4'hD, 8'h05, 8'h01, 12'h232},  // R10
    {16'h6FF0, 8'h00, 4'hF, 8'hF0, 8'hF0, 12'h234},
    {16'h8FB4, 8'h00, 4'hF, 8'h01, 8'h01, 12'h236},  // R7 flag wins
    {16'h6F01, 8'h00, 4'hF, 8'h01, 8'h01, 12'h238},
    {16'h8FB5, 8'h00, 4'hF, 8'h00, 8'h00, 12'h23A},  // R7 flag wins
    {16'hFA15, 8'h00, 4'hA, 8'h03, 8'h00, 12'h23C},  // R11
    {16'hFB18, 8'h00, 4'hB, 8'hFF, 8'h00, 12'h23E},  // R11
    {16'hFE07, 8'h00, 4'hE, 8'h03, 8'h00, 12'h240},  // R11
    {16'hA123, 8'h00, 4'hA, 8'h03, 8'h00, 12'h242},  // R3
    {16'hFB1E, 8'h00, 4'hB, 8'hFF, 8'h00, 12'h244},  // R11
    {16'h1456, 8'h00, 4'hA, 8'h03, 8'h00, 12'h456}   // R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rreg(input logic [3:0] s);
    rd_sel = s;
    return rd_data;
  endfunction

  task automatic issue(input logic [15:0] w, input logic [7:0] r);
    @(negedge clk);
    ins_valid = 1'b1;
    ins_word  = w;
    rnd_byte  = r;
    @(posedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic get_reg(input logic [3:0] s, output logic [7:0] v);
    rd_sel = s;
    #0.1;
    v = rd_data;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pc", pc, 12'h200);
    check("R1 sp", sp, 12'hEA0);
    check("R1 idx", idx, 0);
    check("R1 timers", {dly, snd}, 0);
    check("R1 ctl", {ins_ready, stk_valid, ext_stb, trap}, 4'b1000);
    for (int r = 0; r < 16; r++) begin
      get_reg(r[3:0], v);
      check("R1 reg", v, 0);
    end

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][55:40], VEC[i][39:32]);
      get_reg(VEC[i][31:28], v);
      check("R3-R11 table reg", v, VEC[i][27:20]);
      get_reg(4'hF, v);
      check("R7 table flag", v, VEC[i][19:12]);
      check("R4 table pc", pc, VEC[i][11:0]);
    end
    check("R11 idx", idx, 12'h222);
    check("R11 dly", dly, 8'h03);
    check("R11 snd", snd, 8'hFF);

    // R2 idle hold
    repeat (3) @(negedge clk);
    check("R2 hold pc", pc, 12'h456);

    // R8 call with stalled stack port
    issue(16'h2300, 8'h00);
    check("R8 sp", sp, 12'hE9E);
    for (int s = 0; s < 3; s++) begin
      check("R8 req", {stk_valid, stk_we}, 2'b11);
      check("R2 ready low", ins_ready, 1'b0);
      check("R8 addr", stk_addr, 12'hE9E);
      check("R8 data", stk_wdata, 16'h0458);
      @(negedge clk);
    end
    saved_wr = stk_wdata;
    stk_ready = 1'b1;
    @(negedge clk);
    stk_ready = 1'b0;
    check("R8 pc", pc, 12'h300);
    check("R8 done", {stk_valid, ins_ready}, 2'b01);

    // R9 return, upper bits of read data ignored
    issue(16'h00EE, 8'h00);
    check("R9 req", {stk_valid, stk_we}, 2'b10);
    check("R9 addr", stk_addr, 12'hE9E);
    @(negedge clk);
    stk_rdata = {4'hF, saved_wr[11:0]};
    stk_ready = 1'b1;
    @(negedge clk);
    stk_ready = 1'b0;
    check("R9 pc", pc, 12'h458);
    check("R9 sp", sp, 12'hEA0);

    // R12 dispatch
    issue(16'hD125, 8'h00);
    check("R12 stb", ext_stb, 1'b1);
    check("R12 word", ext_word, 16'hD125);
    check("R12 pc", pc, 12'h45A);
    get_reg(4'hF, v);
    check("R12 flag kept", v, 8'h00);
    @(negedge clk);
    check("R12 one cycle", ext_stb, 1'b0);
    issue(16'hF233, 8'h00);
    check("R12 stb2", {ext_stb, ext_word}, {1'b1, 16'hF233});
    check("R12 pc2", pc, 12'h45C);

    // R13 illegal words
    issue(16'h8AB7, 8'h00);
    check("R13 trap", trap, 1'b1);
    check("R13 pc", pc, 12'h45C);
    get_reg(4'hA, v);
    check("R13 reg kept", v, 8'h03);
    @(negedge clk);
    check("R13 one cycle", trap, 1'b0);
    issue(16'h5AB1, 8'h00);
    check("R13 class5", {trap, pc}, {1'b1, 12'h45C});
    issue(16'h0123, 8'h00);
    check("R13 class0", {trap, pc}, {1'b1, 12'h45C});
    issue(16'hB000, 8'h00);
    check("R13 classB", {trap, pc}, {1'b1, 12'h45C});

    summary();
  end
endmodule